// File: doc/BRIEF.md
# Write-Back Cache Flush Sequencer

This block runs the flush of a write-back cache. It accepts three kinds of request. The first is a command that only invalidates. The second is a command that writes back and then invalidates. The third is an external flush input that works like the second. Once it accepts a request, it walks the tag/state array one line at a time through a single-port read/clear interface whose read data arrives one cycle after the address. Each line that is both valid and modified is sent to a burst-write stub as one line write-back request, using a valid/ready handshake.

After the walk, the block clears every line. It then presents the closing special bus cycles on a second valid/ready handshake. A write-back flush presents a write-back acknowledge cycle followed by a flush acknowledge cycle. An invalidate-only request presents only the flush acknowledge cycle. A write-back flush also enforces a minimum scan time that depends on the line count. No request can cut the sequence short; only reset stops it.

Top module: `flush_seq`

## Requirements
- R1: After reset, `busy`, `wb_valid`, `sp_valid` and `arr_clr` are all low.
- R2: A write-back-and-invalidate request produces exactly one line write-back for each line that was valid and modified, at address {tag, line index, zero offset}. Clean or invalid lines produce none.
- R3: When a sequence completes, every line of the array has both its valid bit and its modified bit cleared.
- R4: A write-back flush ends with exactly two special cycles. The first is the write-back acknowledge, with active-low byte enables 0111. The second is the flush acknowledge, with byte enables 1101. Each special cycle drives sp_addr (A31..A2) to zero, memory/IO = 0, data/control = 0 and write/read = 1.
- R5: An invalidate-only request produces no line write-backs, even when modified lines exist. It clears the array and presents only the flush acknowledge special cycle (byte enables 1101).
- R6: A one-cycle pulse on `flush_req` behaves exactly like a write-back-and-invalidate request.
- R7: In a write-back flush, the number of cycles with `busy` high and neither `wb_valid` nor `sp_valid` high is at least SCAN_FLOOR = FLOOR_PER_LINE*NUM_LINES+FLOOR_EXTRA (66 with the defaults). The cycles spent on write-backs add to this time.
- R8: `busy` rises in the cycle after a request is accepted. It stays high until the handshake of the final special cycle, and it is low in the cycle that follows that handshake.
- R9: Requests that arrive while `busy` is high are ignored. No extra write-back, special cycle or busy period follows.
- R10: If an invalidate-only request and a write-back request arrive in the same cycle, the write-back flush is performed.
- R11: While `wb_valid` or `sp_valid` is high without its ready, the valid stays high and the address or byte enables stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_req | input | 1 | Invalidate-only request |
| wbinv_req | input | 1 | Write-back-then-invalidate request |
| flush_req | input | 1 | External flush input, acts like wbinv_req |
| busy | output | 1 | Sequence in progress |
| arr_addr | output | IDX_W | Line index for the tag/state array |
| arr_clr | output | 1 | Clear valid and modified bits of the line at arr_addr |
| arr_rdata | input | TAG_W+2 | Array read data, one cycle after arr_addr: [TAG_W+1] valid, [TAG_W] modified, rest tag |
| wb_valid | output | 1 | Line write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | ADDR_W | Line address of the write-back |
| sp_valid | output | 1 | Special bus cycle request |
| sp_ready | input | 1 | Special cycle accepted |
| sp_addr | output | ADDR_W-2 | Address bits A31..A2 of the special cycle |
| sp_mio | output | 1 | Memory/IO qualifier |
| sp_dc | output | 1 | Data/control qualifier |
| sp_wr | output | 1 | Write/read qualifier |
| sp_be_n | output | 4 | Active-low byte enables BE3..BE0 |

## Verification
Every cycle, the assertions check four things. The handshake outputs stay stable while they wait for ready. The block stays quiet when idle. Every special cycle is encoded as a zero-address write with a legal byte-enable pattern, and a write-back acknowledge is always followed by a flush acknowledge. Busy falls right after the final handshake. Other properties depend on the array contents and can only be shown by the bench scenarios: that each modified line is written back exactly once with the right address, that invalidate-only skips modified data, that the array ends cleared, that the floor on scan time holds, and that a request arriving mid-sequence is ignored.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_EVAL,
    ST_WB,
    ST_CLR,
    ST_PAD,
    ST_SPWB,
    ST_SPFL
  } fsm_t;

  typedef enum logic {
    SP_WRITEBACK,
    SP_FLUSH
  } sp_kind_t;

  localparam logic [3:0] BE_N_WRITEBACK = 4'b0111;
  localparam logic [3:0] BE_N_FLUSH     = 4'b1101;

endpackage

// File: rtl/flush_req_arb.sv
module flush_req_arb (
  input  logic idle,
  input  logic inv_req,
  input  logic wbinv_req,
  input  logic flush_req,
  output logic start,
  output logic wb_mode
);
  // Write-back requests win over invalidate-only so modified data survives.
  always_comb begin
    wb_mode = wbinv_req | flush_req;
    start   = idle & (wb_mode | inv_req);
  end
endmodule

// File: rtl/flush_floor_ctr.sv
module flush_floor_ctr #(
  parameter int FLOOR = 66
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic reached
);
  localparam int CW = $clog2(FLOOR + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick && cnt != CW'(FLOOR)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // True when the current counted cycle is the FLOOR-th one or later.
  assign reached = (cnt >= CW'(FLOOR - 1));
endmodule

// File: rtl/flush_sp_enc.sv
module flush_sp_enc
  import flush_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  sp_kind_t          kind,
  output logic [ADDR_W-3:0] sp_addr,
  output logic              sp_mio,
  output logic              sp_dc,
  output logic              sp_wr,
  output logic [3:0]        sp_be_n
);
  always_comb begin
    sp_addr = '0;
    sp_mio  = 1'b0;
    sp_dc   = 1'b0;
    sp_wr   = 1'b1;
    sp_be_n = (kind == SP_WRITEBACK) ? BE_N_WRITEBACK : BE_N_FLUSH;
  end
endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import flush_pkg::*;
#(
  parameter int NUM_LINES      = 16,
  parameter int ADDR_W         = 32,
  parameter int LINE_BYTES     = 16,
  parameter int FLOOR_PER_LINE = 4,
  parameter int FLOOR_EXTRA    = 2,
  localparam int IDX_W         = $clog2(NUM_LINES),
  localparam int OFF_W         = $clog2(LINE_BYTES),
  localparam int TAG_W         = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_req,
  input  logic              wbinv_req,
  input  logic              flush_req,
  output logic              busy,
  output logic [IDX_W-1:0]  arr_addr,
  output logic              arr_clr,
  input  logic [TAG_W+1:0]  arr_rdata,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              sp_valid,
  input  logic              sp_ready,
  output logic [ADDR_W-3:0] sp_addr,
  output logic              sp_mio,
  output logic              sp_dc,
  output logic              sp_wr,
  output logic [3:0]        sp_be_n
);
  localparam int SCAN_FLOOR = FLOOR_PER_LINE * NUM_LINES + FLOOR_EXTRA;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  fsm_t             state;
  logic [IDX_W-1:0] idx;
  logic             wb_mode_q;
  logic             start;
  logic             arb_wb;
  logic             floor_ok;
  logic             floor_tick;
  logic             line_dirty;
  logic             last_line;
  sp_kind_t         kind;

  flush_req_arb u_arb (
    .idle      (state == ST_IDLE),
    .inv_req   (inv_req),
    .wbinv_req (wbinv_req),
    .flush_req (flush_req),
    .start     (start),
    .wb_mode   (arb_wb)
  );

  assign floor_tick = wb_mode_q &&
                      (state == ST_RD || state == ST_EVAL ||
                       state == ST_CLR || state == ST_PAD);

  flush_floor_ctr #(.FLOOR(SCAN_FLOOR)) u_floor (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .tick    (floor_tick),
    .reached (floor_ok)
  );

  assign line_dirty = arr_rdata[TAG_W+1] & arr_rdata[TAG_W];
  assign last_line  = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      wb_mode_q <= 1'b0;
      wb_addr   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            wb_mode_q <= arb_wb;
            idx       <= '0;
            state     <= arb_wb ? ST_RD : ST_CLR;
          end
        end
        ST_RD: state <= ST_EVAL;
        ST_EVAL: begin
          if (line_dirty) begin
            wb_addr <= {arr_rdata[TAG_W-1:0], idx, {OFF_W{1'b0}}};
            state   <= ST_WB;
          end else if (last_line) begin
            idx   <= '0;
            state <= ST_CLR;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_RD;
          end
        end
        ST_WB: begin
          if (wb_ready) begin
            if (last_line) begin
              idx   <= '0;
              state <= ST_CLR;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_RD;
            end
          end
        end
        ST_CLR: begin
          if (last_line) begin
            idx   <= '0;
            state <= wb_mode_q ? ST_PAD : ST_SPFL;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PAD:  if (floor_ok) state <= ST_SPWB;
        ST_SPWB: if (sp_ready) state <= ST_SPFL;
        ST_SPFL: if (sp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign arr_addr = idx;
  assign arr_clr  = (state == ST_CLR);
  assign wb_valid = (state == ST_WB);
  assign sp_valid = (state == ST_SPWB) || (state == ST_SPFL);
  assign kind     = (state == ST_SPWB) ? SP_WRITEBACK : SP_FLUSH;

  flush_sp_enc #(.ADDR_W(ADDR_W)) u_enc (
    .kind    (kind),
    .sp_addr (sp_addr),
    .sp_mio  (sp_mio),
    .sp_dc   (sp_dc),
    .sp_wr   (sp_wr),
    .sp_be_n (sp_be_n)
  );
endmodule

// File: rtl/flush_seq_chk.sv
module flush_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              arr_clr,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              sp_valid,
  input logic              sp_ready,
  input logic [ADDR_W-3:0] sp_addr,
  input logic              sp_mio,
  input logic              sp_dc,
  input logic              sp_wr,
  input logic [3:0]        sp_be_n
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!wb_valid && !sp_valid && !arr_clr)); // R1

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr))); // R11

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sp_valid && !sp_ready) |=> (sp_valid && $stable(sp_be_n))); // R11

  AST_SP_ENCODING: assert property (@(posedge clk) disable iff (rst)
    sp_valid |-> (sp_addr == '0 && !sp_mio && !sp_dc && sp_wr &&
                  (sp_be_n == 4'b0111 || sp_be_n == 4'b1101))); // R4

  AST_FLUSH_FOLLOWS_WB: assert property (@(posedge clk) disable iff (rst)
    (sp_valid && sp_ready && sp_be_n == 4'b0111) |=>
      (sp_valid && sp_be_n == 4'b1101)); // R4

  AST_SINGLE_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && sp_valid) && !(wb_valid && arr_clr)); // R2

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (sp_valid && sp_ready && sp_be_n == 4'b1101) |=> !busy); // R8
endmodule

bind flush_seq flush_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .arr_clr  (arr_clr),
  .wb_valid (wb_valid),
  .wb_ready (wb_ready),
  .wb_addr  (wb_addr),
  .sp_valid (sp_valid),
  .sp_ready (sp_ready),
  .sp_addr  (sp_addr),
  .sp_mio   (sp_mio),
  .sp_dc    (sp_dc),
  .sp_wr    (sp_wr),
  .sp_be_n  (sp_be_n)
);

// File: tb/tb_flush_seq.sv
module tb_flush_seq;
  localparam int N     = 16;
  localparam int AW    = 32;
  localparam int IW    = 4;
  localparam int OW    = 4;
  localparam int TW    = AW - IW - OW;
  localparam int FLOOR = 4 * N + 2;

  logic clk = 0;
  logic rst = 1;
  logic inv_req = 0, wbinv_req = 0, flush_req = 0;
  logic busy, arr_clr, wb_valid, sp_valid;
  logic wb_ready = 0, sp_ready = 0;
  logic [IW-1:0] arr_addr;
  logic [TW+1:0] arr_rdata = '0;
  logic [AW-1:0] wb_addr;
  logic [AW-3:0] sp_addr;
  logic sp_mio, sp_dc, sp_wr;
  logic [3:0] sp_be_n;

  always #5 clk = ~clk;

  flush_seq dut (
    .clk(clk), .rst(rst), .inv_req(inv_req), .wbinv_req(wbinv_req),
    .flush_req(flush_req), .busy(busy), .arr_addr(arr_addr),
    .arr_clr(arr_clr), .arr_rdata(arr_rdata), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr), .sp_valid(sp_valid),
    .sp_ready(sp_ready), .sp_addr(sp_addr), .sp_mio(sp_mio),
    .sp_dc(sp_dc), .sp_wr(sp_wr), .sp_be_n(sp_be_n)
  );

  // Tag/state array model, registered read.
  logic          mem_v [N];
  logic          mem_m [N];
  logic [TW-1:0] mem_t [N];
  logic          ld_en = 0, ld_v = 0, ld_m = 0;
  logic [IW-1:0] ld_idx = '0;
  logic [TW-1:0] ld_t = '0;

  always @(posedge clk) begin
    if (ld_en) begin
      mem_v[ld_idx] <= ld_v;
      mem_m[ld_idx] <= ld_m;
      mem_t[ld_idx] <= ld_t;
    end else if (arr_clr) begin
      mem_v[arr_addr] <= 1'b0;
      mem_m[arr_addr] <= 1'b0;
    end
    arr_rdata <= {mem_v[arr_addr], mem_m[arr_addr], mem_t[arr_addr]};
  end

  int n_checks = 0, n_fail = 0;
  int wb_cnt [N];
  int wb_bad = 0;
  int sp_n = 0;
  logic [3:0] sp_seen [4];
  int quiet = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bus stubs and handshake monitor.
  always begin
    @(negedge clk);
    wb_ready <= ($urandom % 3) != 0;
    sp_ready <= ($urandom % 2) != 0;
    #1;
    if (!rst) begin
      if (busy && !wb_valid && !sp_valid && sp_n == 0) quiet++;
      if (wb_valid && wb_ready) begin
        if (wb_addr[OW-1:0] != '0 || wb_addr[AW-1:IW+OW] != mem_t[wb_addr[IW+OW-1:OW]])
          wb_bad++;
        wb_cnt[wb_addr[IW+OW-1:OW]]++;
      end
      if (sp_valid && sp_ready) begin
        check(sp_addr == '0 && !sp_mio && !sp_dc && sp_wr, "R4",
              {sp_mio, sp_dc, sp_wr}, 1);
        if (sp_n < 4) sp_seen[sp_n] = sp_be_n;
        sp_n++;
      end
    end
  end

  // pattern: 0 random, 1 all modified, 2 all clean
  task automatic run_seq(input bit di, input bit dw, input bit df,
                         input int pattern, input bit poke);
    bit ev [N];
    bit em [N];
    bit wbpath;
    string req;
    int errs;
    int sp_before;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_en  = 1;
      ld_idx = IW'(i);
      ld_t   = TW'($urandom);
      case (pattern)
        1:       begin ld_v = 1; ld_m = 1; end
        2:       begin ld_v = 1; ld_m = 0; end
        default: begin ld_v = $urandom % 2; ld_m = ld_v & ($urandom % 2); end
      endcase
      ev[i] = ld_v;
      em[i] = ld_m;
    end
    @(negedge clk);
    ld_en = 0;
    for (int i = 0; i < N; i++) wb_cnt[i] = 0;
    wb_bad = 0; sp_n = 0; quiet = 0;
    inv_req = di; wbinv_req = dw; flush_req = df;
    @(negedge clk);
    inv_req = 0; wbinv_req = 0; flush_req = 0;
    check(busy == 1'b1, "R8", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      inv_req = 1; flush_req = 1;
      @(negedge clk);
      inv_req = 0; flush_req = 0;
    end
    while (busy) @(negedge clk);
    wbpath = dw | df;
    req = (df && !dw) ? "R6" : ((di && dw) ? "R10" : "R2");
    errs = 0;
    for (int i = 0; i < N; i++)
      if (wb_cnt[i] != ((wbpath && ev[i] && em[i]) ? 1 : 0)) errs++;
    check(errs == 0 && wb_bad == 0, wbpath ? req : "R5", errs + wb_bad, 0);
    errs = 0;
    for (int i = 0; i < N; i++) if (mem_v[i] || mem_m[i]) errs++;
    check(errs == 0, "R3", errs, 0);
    if (wbpath) begin
      check(sp_n == 2, req, sp_n, 2);
      check(sp_seen[0] == 4'b0111 && sp_seen[1] == 4'b1101, "R4",
            {sp_seen[0], sp_seen[1]}, 8'h7D);
      check(quiet >= FLOOR, "R7", quiet, FLOOR);
    end else begin
      check(sp_n == 1 && sp_seen[0] == 4'b1101, "R5", sp_n, 1);
    end
    sp_before = sp_n;
    repeat (12) @(negedge clk);
    check(!busy && sp_n == sp_before, "R9", sp_n, sp_before);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !wb_valid && !sp_valid && !arr_clr, "R1",
          {busy, wb_valid, sp_valid, arr_clr}, 0);
    run_seq(0, 1, 0, 0, 0);  // R2 random mix
    run_seq(0, 0, 1, 0, 0);  // R6 flush pin
    run_seq(1, 0, 0, 1, 0);  // R5 invalidate-only with dirty lines
    run_seq(1, 1, 0, 0, 0);  // R10 both at once
    run_seq(0, 1, 0, 0, 1);  // R9 requests mid-sequence
    run_seq(0, 1, 0, 1, 0);  // all modified
    run_seq(0, 1, 0, 2, 0);  // R7 no write-backs: floor governs
    for (int k = 0; k < 6; k++) begin
      int sel;
      sel = $urandom % 3;
      run_seq(sel == 0, sel == 1, sel == 2, 0, ($urandom % 2) == 1);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule